// File: doc/BRIEF.md
# Configuration Address Translation Unit

This block sits on the host side of a bridge. It turns accesses to two I/O ports into the address phase of bus configuration cycles. Software first writes a 32-bit address word to the address port. The word holds an enable flag, a bus number, a device number, a function number and a dword-aligned register number. Software then reads or writes the data-window port. When the enable flag is set, each window access makes the block issue one registered cycle descriptor. The descriptor carries the full 32-bit AD value, the Type 0 or Type 1 choice, the direction and a master-abort flag.

On bus zero, a device number from 2 up to a parameterised ceiling is decoded into a single select line. Device numbers 0 and 1 are handed to internal functions and do not go onto the bus. Numbers above the ceiling run a cycle with no select line, and that cycle is marked as aborted. An aborted read returns all ones to the host. On any other bus the address is passed through with the Type 1 code in the two low bits. Window accesses made while the enable flag is clear are passed on as ordinary I/O, and so are accesses to any other port.

Every output is registered. A request sampled at one rising edge appears on the outputs right after that edge and lasts for one cycle.

Top module: `cfg_xlate_unit`

## Requirements
- R1: After reset the address register reads 0 and every pulse output is low. A dword write (io_dword=1) to port 0xCF8 loads io_wdata into the address register. A dword read of 0xCF8 gives rd_valid=1 and rd_data equal to the register one cycle later. A non-dword access to 0xCF8 neither loads nor reads the register; it raises io_pass instead.
- R2: While address bit 31 is 0, an access to the window port 0xCFC raises io_pass and leaves cyc_start and cyc_internal low. An access to any port other than 0xCF8 or 0xCFC also raises io_pass.
- R3: When bits 23:16 (bus) are zero and the enable is set, a window access gives cyc_type1=0, AD[10:2] equal to address bits 10:2 (function in 10:8, register in 7:2) and AD[1:0]=00.
- R4: In a Type 0 cycle to device d (address bits 15:11) with 2 <= d <= 20, AD[31:11] has exactly one bit set, at position d+11, and cyc_start=1 with cyc_abort=0.
- R5: A Type 0 access to device 0 or 1 pulses cyc_internal with cyc_int_dev equal to d. cyc_start stays low and no abort is flagged.
- R6: A Type 0 access to a device above 20 pulses cyc_start with AD[31:11] all zero and cyc_abort=1.
- R7: With a non-zero bus the cycle is Type 1: cyc_type1=1, AD[23:2] equals address bits 23:2, AD[1:0]=01, AD[31:24]=0. cyc_abort and cyc_internal stay low for every device number.
- R8: An aborted configuration read returns rd_valid=1 with rd_data=0xFFFFFFFF. An aborted write produces no rd_valid.
- R9: cyc_write equals io_write of the window access that produced the cycle or internal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O request present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_dword | input | 1 | Request is a full 32-bit access |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data returned by this block |
| rd_data | output | 32 | Address readback or abort all-ones |
| io_pass | output | 1 | Request forwarded as ordinary I/O |
| cyc_start | output | 1 | Bus configuration cycle address phase |
| cyc_ad | output | 32 | AD value for the address phase |
| cyc_type1 | output | 1 | 1 = Type 1 encoding |
| cyc_write | output | 1 | Direction of the cycle |
| cyc_abort | output | 1 | Cycle has no select line and ends in master abort |
| cyc_internal | output | 1 | Access routed to an internal function |
| cyc_int_dev | output | 1 | Internal function index (device 0 or 1) |

## Verification
The bus-number test and the device-ceiling test fall in the same cycle whenever a window access names a device above 20. On bus zero the ceiling test has to abort the cycle. On any other bus the Type 1 path has to win, with no abort and the address copied through. The bench provokes this overlap by sweeping all 32 device numbers, for reads and for writes, on both a zero and a non-zero bus. It computes the expected select position, AD value, abort flag and returned data arithmetically for each case. The window port is always accessed in the cycle right after the address load, so the new address must take effect without a gap.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef struct packed {
        logic [31:0] addr_reg;
        logic        rd_valid;
        logic [31:0] rd_data;
        logic        io_pass;
        logic        start;
        logic [31:0] ad;
        logic        type1;
        logic        write;
        logic        abort;
        logic        internal;
        logic        int_dev;
    } cfg_state_t;

endpackage

// File: rtl/cfg_dev_decode.sv
module cfg_dev_decode #(
    parameter int DEV_W     = 5,
    parameter int FIRST_DEV = 2,
    parameter int LAST_DEV  = 20,
    localparam int SEL_W    = LAST_DEV - FIRST_DEV + 1
) (
    input  logic [DEV_W-1:0] dev_i,
    output logic [SEL_W-1:0] sel_o
);

    for (genvar i = 0; i < SEL_W; i++) begin : g_sel
        assign sel_o[i] = (dev_i == DEV_W'(FIRST_DEV + i));
    end

endmodule

// File: rtl/cfg_ad_build.sv
module cfg_ad_build #(
    parameter int FIRST_DEV = 2,
    parameter int LAST_DEV  = 20
) (
    input  logic [23:2] addr_i,
    output logic [31:0] ad_o,
    output logic        type1_o,
    output logic        abort_o,
    output logic        internal_o
);

    localparam int SEL_W   = LAST_DEV - FIRST_DEV + 1;
    localparam int SEL_LSB = 32 - SEL_W;

    logic [7:0]       bus;
    logic [4:0]       dev;
    logic [SEL_W-1:0] sel;

    assign bus = addr_i[23:16];
    assign dev = addr_i[15:11];

    cfg_dev_decode #(
        .DEV_W    (5),
        .FIRST_DEV(FIRST_DEV),
        .LAST_DEV (LAST_DEV)
    ) u_dec (
        .dev_i(dev),
        .sel_o(sel)
    );

    always_comb begin
        type1_o    = (bus != 8'h00);
        abort_o    = 1'b0;
        internal_o = 1'b0;
        if (type1_o) begin
            ad_o = {8'h00, addr_i[23:2], 2'b01};
        end else begin
            ad_o = '0;
            ad_o[SEL_LSB +: SEL_W] = sel;
            ad_o[10:2]             = addr_i[10:2];
            abort_o    = (dev > 5'(LAST_DEV));
            internal_o = (dev < 5'(FIRST_DEV));
        end
    end

endmodule

// File: rtl/cfg_xlate_unit.sv
module cfg_xlate_unit #(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter int          FIRST_DEV = 2,
    parameter int          LAST_DEV  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_valid,
    input  logic             io_write,
    input  logic             io_dword,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [31:0]      io_wdata,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic             io_pass,
    output logic             cyc_start,
    output logic [31:0]      cyc_ad,
    output logic             cyc_type1,
    output logic             cyc_write,
    output logic             cyc_abort,
    output logic             cyc_internal,
    output logic             cyc_int_dev
);

    import cfg_pkg::*;

    localparam int SEL_LSB = 32 - (LAST_DEV - FIRST_DEV + 1);

    cfg_state_t st_d, st_q;

    logic [31:0] b_ad;
    logic        b_type1, b_abort, b_internal;
    logic        hit_addr, hit_data;

    assign hit_addr = (io_addr == IO_AW'(ADDR_PORT));
    assign hit_data = (io_addr == IO_AW'(DATA_PORT));

    cfg_ad_build #(
        .FIRST_DEV(FIRST_DEV),
        .LAST_DEV (LAST_DEV)
    ) u_build (
        .addr_i    (st_q.addr_reg[23:2]),
        .ad_o      (b_ad),
        .type1_o   (b_type1),
        .abort_o   (b_abort),
        .internal_o(b_internal)
    );

    always_comb begin
        st_d          = '0;
        st_d.addr_reg = st_q.addr_reg;
        if (io_valid) begin
            if (hit_addr && io_dword) begin
                if (io_write) begin
                    st_d.addr_reg = io_wdata;
                end else begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = st_q.addr_reg;
                end
            end else if (hit_data && st_q.addr_reg[31]) begin
                st_d.write = io_write;
                st_d.ad    = b_ad;
                st_d.type1 = b_type1;
                if (b_internal) begin
                    st_d.internal = 1'b1;
                    st_d.int_dev  = st_q.addr_reg[11];
                end else begin
                    st_d.start = 1'b1;
                    st_d.abort = b_abort;
                    if (b_abort && !io_write) begin
                        st_d.rd_valid = 1'b1;
                        st_d.rd_data  = '1;
                    end
                end
            end else begin
                st_d.io_pass = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid     = st_q.rd_valid;
    assign rd_data      = st_q.rd_data;
    assign io_pass      = st_q.io_pass;
    assign cyc_start    = st_q.start;
    assign cyc_ad       = st_q.ad;
    assign cyc_type1    = st_q.type1;
    assign cyc_write    = st_q.write;
    assign cyc_abort    = st_q.abort;
    assign cyc_internal = st_q.internal;
    assign cyc_int_dev  = st_q.int_dev;

    AST_DISABLED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && hit_data && !st_q.addr_reg[31]) |=> (!cyc_start && !cyc_internal && io_pass)); // R2
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !cyc_type1) |-> $onehot0(cyc_ad[31:SEL_LSB])); // R4
    AST_INTERNAL_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_internal |-> (!cyc_start && !cyc_abort)); // R5
    AST_ABORT_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_abort |-> (cyc_start && !cyc_type1 && cyc_ad[31:11] == '0)); // R6
    AST_TYPE1_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cyc_type1) |-> (cyc_ad[1:0] == 2'b01 && cyc_ad[31:24] == 8'h00 && !cyc_abort)); // R7
    AST_ABORT_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_abort && !cyc_write) |-> (rd_valid && rd_data == 32'hFFFF_FFFF)); // R8
    AST_ABORT_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_abort && cyc_write) |-> !rd_valid); // R8

endmodule

// File: tb/sim_cfg_xlate_unit.sv
module sim_cfg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0, io_write = 1'b0, io_dword = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic        rd_valid, io_pass, cyc_start, cyc_type1, cyc_write;
    logic        cyc_abort, cyc_internal, cyc_int_dev;
    logic [31:0] rd_data, cyc_ad;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_xlate_unit u0 (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_dword(io_dword), .io_addr(io_addr), .io_wdata(io_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .io_pass(io_pass),
        .cyc_start(cyc_start), .cyc_ad(cyc_ad), .cyc_type1(cyc_type1),
        .cyc_write(cyc_write), .cyc_abort(cyc_abort), .cyc_internal(cyc_internal),
        .cyc_int_dev(cyc_int_dev)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One request, driven at a falling edge; outputs sampled just after the next rising edge.
    task automatic io(input logic w, input logic [15:0] a, input logic dw, input logic [31:0] d);
        @(negedge clk);
        io_valid = 1'b1; io_write = w; io_addr = a; io_dword = dw; io_wdata = d;
        @(posedge clk);
        #1;
        io_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, exp_ad;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "reset start", {31'b0, cyc_start}, 0);
        chk("R1", "reset pass", {31'b0, io_pass}, 0);
        chk("R1", "reset rd_valid", {31'b0, rd_valid}, 0);

        io(1'b0, 16'h0CF8, 1'b1, 0);
        chk("R1", "reset readback valid", {31'b0, rd_valid}, 1);
        chk("R1", "reset readback", rd_data, 0);

        io(1'b1, 16'h0CF8, 1'b1, 32'h1234_5678);
        io(1'b0, 16'h0CF8, 1'b1, 0);
        chk("R1", "readback", rd_data, 32'h1234_5678);
        io(1'b1, 16'h0CF8, 1'b0, 32'hDEAD_BEEF);
        chk("R1", "partial write passes", {31'b0, io_pass}, 1);
        io(1'b0, 16'h0CF8, 1'b0, 0);
        chk("R1", "partial read no data", {31'b0, rd_valid}, 0);
        io(1'b0, 16'h0CF8, 1'b1, 0);
        chk("R1", "partial write ignored", rd_data, 32'h1234_5678);

        // Enable clear: window access becomes ordinary I/O
        for (int rw = 0; rw < 2; rw++) begin
            io(1'b0, 16'h0CFC, 1'b1, 0);
            chk("R2", "disabled pass", {31'b0, io_pass}, 1);
            chk("R2", "disabled start", {31'b0, cyc_start}, 0);
            chk("R2", "disabled internal", {31'b0, cyc_internal}, 0);
        end
        io(1'b1, 16'h0080, 1'b1, 32'h5);
        chk("R2", "other port pass", {31'b0, io_pass}, 1);

        for (int bi = 0; bi < 2; bi++) begin
            for (int dev = 0; dev < 32; dev++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    logic [7:0] bus;
                    bus = (bi == 0) ? 8'h00 : 8'h5A;
                    a = {1'b1, 7'h00, bus, 5'(dev), 3'(dev ^ 5), 6'(dev * 3 + rw), 2'b00};
                    io(1'b1, 16'h0CF8, 1'b1, a);
                    io(1'(rw), 16'h0CFC, 1'b1, 32'h0);
                    chk("R2", "no pass when enabled", {31'b0, io_pass}, 0);
                    chk("R9", "direction", {31'b0, cyc_write}, 32'(rw));
                    if (bi != 0) begin
                        exp_ad = (a & 32'h00FF_FFFC) | 32'h1;
                        chk("R7", "type1 flag", {31'b0, cyc_type1}, 1);
                        chk("R7", "type1 ad", cyc_ad, exp_ad);
                        chk("R7", "type1 start", {31'b0, cyc_start}, 1);
                        chk("R7", "type1 no abort", {31'b0, cyc_abort}, 0);
                        chk("R7", "type1 not internal", {31'b0, cyc_internal}, 0);
                    end else if (dev < 2) begin
                        chk("R5", "internal", {31'b0, cyc_internal}, 1);
                        chk("R5", "internal index", {31'b0, cyc_int_dev}, 32'(dev));
                        chk("R5", "no bus cycle", {31'b0, cyc_start}, 0);
                        chk("R5", "no abort", {31'b0, cyc_abort}, 0);
                    end else begin
                        chk("R3", "type0 flag", {31'b0, cyc_type1}, 0);
                        chk("R3", "type0 low bits", cyc_ad & 32'h7FF, a & 32'h7FC);
                        chk("R4", "start", {31'b0, cyc_start}, 1);
                        if (dev <= 20) begin
                            exp_ad = 32'h1 << (dev + 11);
                            chk("R4", "select", cyc_ad & 32'hFFFF_F800, exp_ad);
                            chk("R4", "no abort", {31'b0, cyc_abort}, 0);
                            chk("R8", "no rd on good cycle", {31'b0, rd_valid}, 0);
                        end else begin
                            chk("R6", "no select", cyc_ad & 32'hFFFF_F800, 0);
                            chk("R6", "abort", {31'b0, cyc_abort}, 1);
                            chk("R8", "abort rd_valid", {31'b0, rd_valid}, (rw == 0) ? 1 : 0);
                            if (rw == 0) chk("R8", "abort ones", rd_data, 32'hFFFF_FFFF);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule